// File: doc/BRIEF.md
# Forwarded-Clock Serial Lane Deserializer

The block sits behind the line receivers of a display link. Each serial data lane, and a separate lane that carries the forwarded pixel clock, is sampled once per bit clock. The bit clock runs at seven times the pixel rate. From the clock lane the block finds where each seven-bit word starts. It then gathers seven bits from every data lane into one wide parallel word and presents that word with a one-cycle valid strobe and a rebuilt pixel clock.

The lane count is a parameter: four lanes give a 28-bit word and three lanes give a 21-bit word. The output is a stream with valid and no ready. A serial line cannot be stalled, so the consumer must accept every word in the cycle its valid is high. Back-pressure is therefore not supported, and a sink that cannot keep up loses words.

An active-low power-down forces the outputs to a quiet state. When the clock-lane pattern disappears, a fail-safe state keeps the last good word on the outputs and stops the clock.

Top module: `lane_deser`

## Requirements
- R1: Data lane L carries word bits L*7+6 down to L*7 in that order, the highest bit first. A word whose clock-lane pattern matches is presented on `word_o` with exactly these bit positions.
- R2: With LANES=3 the word is 21 bits wide and follows the same per-lane mapping as R1.
- R3: The clock lane carries 1,1,0,0,0,1,1 in arrival order for each word. Lock is reached after three matches spaced exactly seven bit clocks apart. The first word presented is the one carrying the fourth match, and no word is presented before it.
- R4: `word_valid_o` is high for one bit clock per presented word, and two strobes are at least seven bit clocks apart. Between strobes `word_o` holds its value.
- R5: Once locked, `pix_clk_o` is high for four bit clocks and low for three. Its rising edge falls in the same cycle as `word_valid_o`.
- R6: While `pwr_n` is low, `word_o` is zero and `word_valid_o`, `pix_clk_o` and `failsafe_o` are low. After `pwr_n` returns high, alignment starts again from the search of R3.
- R7: When locked and the clock pattern is missing at four word boundaries in a row, `failsafe_o` goes high. While it is high, `pix_clk_o` and `word_valid_o` stay low and `word_o` keeps the last presented word.
- R8: From fail-safe, three new matching words regain lock and clear `failsafe_o`, and presentation resumes with the fourth word.
- R9: After reset, `word_o` is zero and `word_valid_o`, `pix_clk_o` and `failsafe_o` are low.
- R10: A run of fewer than four missing patterns while locked skips those words only. Lock is kept, and the next matching word is presented without a new search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven per pixel period |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_n | input | 1 | Active-low power-down |
| lane_bit_i | input | LANES | One sampled bit per data lane per bit clock |
| clk_lane_i | input | 1 | Sampled bit of the forwarded clock lane |
| word_o | output | LANES*7 | Rebuilt parallel word |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| pix_clk_o | output | 1 | Rebuilt pixel clock |
| failsafe_o | output | 1 | Clock-lane pattern lost |

## Verification
The bench builds two copies side by side: one with LANES=4 and one with LANES=3. Both are fed the same lane stream, so the 21-bit variant is checked against the low lanes of every 28-bit word. Both copies keep the default lock threshold of three and the default miss limit of four. This keeps the lock search, a single skipped word, fail-safe entry and relock all within a few hundred bit clocks, so each can be stepped through at exact word boundaries.

// File: rtl/lane_deser_pkg.sv
package lane_deser_pkg;
  localparam int unsigned SLOTS = 7;
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;
  typedef enum logic [1:0] {
    AL_SEARCH = 2'd0,
    AL_LOCKED = 2'd1,
    AL_LOST   = 2'd2
  } align_state_e;
endpackage

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_i,
  output logic [W-1:0] sh_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) sh_o <= '0;
    else               sh_o <= {sh_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/frame_align.sv
module frame_align import lane_deser_pkg::*; #(
  parameter int unsigned LOCK_HITS  = 3,
  parameter int unsigned MISS_LIMIT = 4,
  localparam int unsigned PW = $clog2(SLOTS),
  localparam int unsigned HW = $clog2(LOCK_HITS + 1),
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic [SLOTS-1:0] ck_word_i,
  output logic             take_o,
  output logic             locked_o,
  output logic             lost_o,
  output logic [PW-1:0]    phase_o
);
  localparam logic [PW-1:0] PH_LAST  = PW'(SLOTS - 1);
  localparam logic [HW-1:0] HIT_LAST = HW'(LOCK_HITS - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

  align_state_e  state;
  logic [HW-1:0] hits;
  logic [MW-1:0] miss;
  logic [PW-1:0] phase;
  logic          match, bnd;

  assign match    = (ck_word_i == CLK_PATTERN);
  assign bnd      = (phase == PH_LAST);
  assign take_o   = (state == AL_LOCKED) && bnd && match;
  assign locked_o = (state == AL_LOCKED);
  assign lost_o   = (state == AL_LOST);
  assign phase_o  = phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_n) begin
      state <= AL_SEARCH;
      hits  <= '0;
      miss  <= '0;
      phase <= '0;
    end else begin
      phase <= bnd ? '0 : phase + 1'b1;
      if (state == AL_LOCKED) begin
        if (bnd) begin
          if (match) begin
            miss <= '0;
          end else if (miss == MISS_LAST) begin
            state <= AL_LOST;
            miss  <= '0;
            hits  <= '0;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end else begin
        if (match) begin
          phase <= '0;
          if (bnd && hits != '0) begin
            if (hits == HIT_LAST) begin
              state <= AL_LOCKED;
              hits  <= '0;
              miss  <= '0;
            end else begin
              hits <= hits + 1'b1;
            end
          end else begin
            hits <= HW'(1);
          end
        end else if (bnd) begin
          hits <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/word_out.sv
module word_out import lane_deser_pkg::*; #(
  parameter int unsigned WIDTH = 28,
  localparam int unsigned PW = $clog2(SLOTS),
  localparam int unsigned HIGH_SLOTS = (SLOTS + 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic             take_i,
  input  logic             locked_i,
  input  logic [PW-1:0]    phase_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o,
  output logic             pix_o
);
  localparam logic [PW-1:0] PH_FALL = PW'(HIGH_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_n) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      pix_o   <= 1'b0;
    end else begin
      valid_o <= take_i;
      if (take_i) word_o <= word_i;
      if (take_i)                          pix_o <= 1'b1;
      else if (!locked_i || phase_i == PH_FALL) pix_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_deser.sv
module lane_deser import lane_deser_pkg::*; #(
  parameter int unsigned LANES      = 4,
  parameter int unsigned LOCK_HITS  = 3,
  parameter int unsigned MISS_LIMIT = 4,
  localparam int unsigned WIDTH = LANES * SLOTS,
  localparam int unsigned PW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic [LANES-1:0] lane_bit_i,
  input  logic             clk_lane_i,
  output logic [WIDTH-1:0] word_o,
  output logic             word_valid_o,
  output logic             pix_clk_o,
  output logic             failsafe_o
);
  logic [SLOTS-1:0] lane_sh [LANES];
  logic [SLOTS-1:0] ck_sh;
  logic [WIDTH-1:0] word_asm;
  logic             take, locked, lost;
  logic [PW-1:0]    phase;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_shifter #(.W(SLOTS)) u_sh (
      .clk(clk), .rst_n(rst_n), .clr(!pwr_n),
      .bit_i(lane_bit_i[g]), .sh_o(lane_sh[g])
    );
    assign word_asm[g*SLOTS +: SLOTS] = lane_sh[g];
  end

  lane_shifter #(.W(SLOTS)) u_ck_sh (
    .clk(clk), .rst_n(rst_n), .clr(!pwr_n),
    .bit_i(clk_lane_i), .sh_o(ck_sh)
  );

  frame_align #(.LOCK_HITS(LOCK_HITS), .MISS_LIMIT(MISS_LIMIT)) u_align (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .ck_word_i(ck_sh),
    .take_o(take), .locked_o(locked), .lost_o(lost), .phase_o(phase)
  );

  word_out #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .take_i(take),
    .locked_i(locked), .phase_i(phase), .word_i(word_asm),
    .word_o(word_o), .valid_o(word_valid_o), .pix_o(pix_clk_o)
  );

  assign failsafe_o = lost && pwr_n;
endmodule

// File: rtl/lane_deser_chk.sv
module lane_deser_chk #(
  parameter int unsigned WIDTH = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_n,
  input logic [WIDTH-1:0] word_o,
  input logic             word_valid_o,
  input logic             pix_clk_o,
  input logic             failsafe_o
);
  logic [2:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (word_valid_o) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 3'd7) begin
      gap <= gap + 1'b1;
    end
  end

  p_valid_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && seen) |-> (gap >= 3'd6));
  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid_o && pwr_n && $past(pwr_n)) |-> $stable(word_o));
  p_valid_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (pix_clk_o && !$past(pix_clk_o)));
  p_pd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (word_o == '0 && !word_valid_o && !pix_clk_o && !failsafe_o));
  p_fs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe_o |-> (!pix_clk_o && !word_valid_o));
  p_fs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (failsafe_o && $past(failsafe_o)) |-> $stable(word_o));
endmodule

bind lane_deser lane_deser_chk #(.WIDTH(LANES * 7)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .word_o(word_o),
  .word_valid_o(word_valid_o), .pix_clk_o(pix_clk_o), .failsafe_o(failsafe_o)
);

// File: tb/lane_deser_tb_top.sv
module lane_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_n = 1'b1;
  logic [3:0]  lane_bit = '0;
  logic        ck_bit = 1'b0;
  logic [27:0] w4;
  logic [20:0] w3;
  logic        v4, v3, p4, p3, f4, f3;
  int          n_tests = 0;
  int          n_fail = 0;
  logic [27:0] exp4 [$];
  logic [20:0] exp3 [$];
  logic [27:0] last_good = '0;
  localparam logic [6:0] PAT = 7'b1100011;

  always #5 clk = ~clk;

  lane_deser #(.LANES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lane_bit_i(lane_bit),
    .clk_lane_i(ck_bit), .word_o(w4), .word_valid_o(v4),
    .pix_clk_o(p4), .failsafe_o(f4));
  lane_deser #(.LANES(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lane_bit_i(lane_bit[2:0]),
    .clk_lane_i(ck_bit), .word_o(w3), .word_valid_o(v3),
    .pix_clk_o(p3), .failsafe_o(f3));

  task automatic check(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Sends one word: lane L carries bits L*7+6 .. L*7, highest first (R1).
  task automatic send_word(input logic [27:0] w, input bit good, input bit expect_out);
    if (expect_out) begin
      exp4.push_back(w);
      exp3.push_back(w[20:0]);
      last_good = w;
    end
    for (int b = 0; b < 7; b++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) lane_bit[l] = w[l*7 + 6 - b];
      ck_bit = good ? PAT[6-b] : 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: scoreboard compare and pixel clock shape.
  int  hi_cnt = 0;
  bit  seen_v = 0;
  bit  prev_p = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!pwr_n) seen_v = 0;
      if (v4) begin
        if (exp4.size() == 0) check(0, "R3 unexpected word 4-lane", w4, '0);
        else begin
          logic [27:0] e;
          e = exp4.pop_front();
          check(w4 == e, "R1 word 4-lane", w4, e);
        end
        check(p4 && !prev_p, "R5 valid on pix rise", {27'd0, p4}, 28'd1);
        if (seen_v) check(hi_cnt == 4, "R5 pix high count", 28'(hi_cnt), 28'd4);
        hi_cnt = 1;
        seen_v = 1;
      end else if (p4) hi_cnt++;
      if (v3) begin
        if (exp3.size() == 0) check(0, "R2 unexpected word 3-lane", {7'd0, w3}, '0);
        else begin
          logic [20:0] e3;
          e3 = exp3.pop_front();
          check(w3 == e3, "R2 word 3-lane", {7'd0, w3}, {7'd0, e3});
        end
      end
      prev_p = p4;
    end
  end

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    // R9 reset state
    check(w4 == 0 && !v4 && !p4 && !f4, "R9 reset 4-lane", w4, '0);
    check(w3 == 0 && !v3 && !p3 && !f3, "R9 reset 3-lane", {7'd0, w3}, '0);
    rst_n = 1'b1;
    send_word(28'h1234567, 0, 0);
    send_word(28'h7654321, 0, 0);
    // R3 three matches lock, nothing presented yet
    send_word(28'hABCDEF1, 1, 0);
    send_word(28'h0F0F0F0, 1, 0);
    send_word(28'h5555555, 1, 0);
    check(w4 == 0 && !p4, "R3 no word before fourth match", w4, '0);
    send_word(28'h0000001, 1, 1);
    send_word(28'hFFFFFFF, 1, 1);
    send_word(28'hA5A5A5A, 1, 1);
    send_word(28'h8000000, 1, 1);
    send_word(28'h0204081, 1, 1);
    send_word(28'h3C96E21, 1, 1);
    // R10 one missing pattern keeps lock
    send_word(28'h1111111, 0, 0);
    idle(2);
    check(w4 == last_good, "R4 word held across skipped word", w4, last_good);
    check(!f4, "R10 no failsafe after one miss", {27'd0, f4}, '0);
    idle(5);
    send_word(28'h2468ACE, 1, 1);
    send_word(28'h1357BDF, 1, 1);
    // R7 fail-safe after four misses
    send_word(28'h0, 0, 0);
    send_word(28'h0, 0, 0);
    send_word(28'h0, 0, 0);
    idle(1);
    check(!f4, "R7 no failsafe after three misses", {27'd0, f4}, '0);
    idle(6);
    send_word(28'h0, 0, 0);
    send_word(28'h0, 0, 0);
    check(f4 && f3, "R7 failsafe set", {27'd0, f4}, 28'd1);
    check(w4 == last_good, "R7 word held in failsafe", w4, last_good);
    begin
      int hi = 0;
      for (int i = 0; i < 7; i++) begin
        @(negedge clk);
        if (p4 || v4) hi++;
      end
      check(hi == 0, "R7 clock low in failsafe", 28'(hi), '0);
    end
    // R8 relock
    send_word(28'h1010101, 1, 0);
    send_word(28'h2020202, 1, 0);
    send_word(28'h4040404, 1, 0);
    send_word(28'h7E7E7E7, 1, 1);
    check(!f4 && !f3, "R8 failsafe cleared on relock", {27'd0, f4}, '0);
    send_word(28'h0C0C0C0, 1, 1);
    idle(3);
    // R6 power-down
    pwr_n = 1'b0;
    send_word(28'h9999999, 1, 0);
    check(w4 == 0 && !v4 && !p4 && !f4, "R6 outputs low in power-down", w4, '0);
    check(w3 == 0 && !p3, "R6 3-lane low in power-down", {7'd0, w3}, '0);
    pwr_n = 1'b1;
    send_word(28'h6666666, 1, 0);
    send_word(28'h7777777, 1, 0);
    send_word(28'h3333333, 1, 0);
    check(w4 == 0 && !p4, "R6 relock required after power-down", w4, '0);
    send_word(28'hDEADBEE, 1, 1);
    send_word(28'h0BADCAF, 1, 1);
    idle(10);
    check(exp4.size() == 0, "R1 all 4-lane words presented", 28'(exp4.size()), '0);
    check(exp3.size() == 0, "R2 all 3-lane words presented", 28'(exp3.size()), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule